// File: doc/BRIEF.md
# Quad Common-Trigger Delay Generator

This block times four programmable delays from a single shared trigger. One elapsed-time counter starts on an accepted trigger, and each channel compares it with its own 24-bit delay. When a channel's delay runs out, its level output goes high and stays high. At the same moment its pulse output emits a pulse of fixed width. The delays are counted in whole clock cycles.

Channels are paired as 0/1 and 2/3. A pair can be coupled so that the lower channel's level becomes a window. A busy flag and two status flags track the run. Software or a sequencer sets the delays through a simple write port. It then picks the pairing, the busy span and a retrigger policy, and fires the trigger. A clear input ends a run and leaves the stored delays as they are.

Top module: `dgq_top`

## Requirements
- R1: In uncoupled operation, channel k's level output rises exactly max(Dk,1) clock cycles after the edge that accepts a trigger. It stays high until a clear or an accepted retrigger.
- R2: A stored delay of 0 behaves exactly like a delay of 1.
- R3: When channel k's delay elapses, its pulse output is high for PULSE_W consecutive cycles, starting in the cycle where its level would rise.
- R4: With pair bit p set, the level of channel 2p is high from the elapse of D(2p) until the elapse of D(2p+1). If D(2p) is not smaller than D(2p+1), the window is empty. The level of channel 2p+1 behaves as in R1.
- R5: Busy is high from the cycle after an accepted trigger. It falls when the first channel elapses (busyLongest=0) or when all four have elapsed (busyLongest=1).
- R6: shortDone is high once any channel has elapsed in the current run. longDone is high once all four have elapsed.
- R7: Clear zeroes all levels, pulses, busy and status. A trigger in the same cycle as a clear is ignored. Stored delays survive a clear.
- R8: retrigMode 0 or 3 (no retrigger): once a run has started, triggers are ignored until a clear.
- R9: retrigMode 1 (gap retrigger): a trigger is accepted once MIN_GAP cycles have passed since the last accepted one. Earlier triggers are ignored. An accepted retrigger restarts all timing and drops levels and pulses.
- R10: retrigMode 2 (retrigger after the longest delay): a trigger during a run is accepted only after all four channels have elapsed.
- R11: readyOut is high exactly when a trigger at the next edge would be accepted, if clear is low.
- R12: After reset, all levels, pulses, busy and status are low, readyOut is high, and every stored delay is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | 1 | Shared trigger request, sampled each edge |
| clearIn | input | 1 | Ends the run; stored delays are kept |
| wrEn | input | 1 | Write strobe for a delay register |
| wrSel | input | 2 | Channel selected for the write |
| wrData | input | 24 | Delay value in clock cycles |
| couplePair | input | 2 | Bit p couples channels 2p and 2p+1 into a window |
| busyLongest | input | 1 | 0: busy spans the shortest delay; 1: busy spans the longest |
| retrigMode | input | 2 | 0/3 none, 1 gap, 2 after the longest delay |
| levelOut | output | 4 | Per-channel level outputs |
| pulseOut | output | 4 | Per-channel fixed-width pulses |
| busyOut | output | 1 | Run in progress |
| shortDone | output | 1 | Some channel has elapsed |
| longDone | output | 1 | Every channel has elapsed |
| readyOut | output | 1 | A trigger would be accepted |

## Verification
Inputs are driven on the falling edge and take effect at the next rising edge. A level or pulse for delay D appears after the D-th rising edge that follows the accepting edge. Busy, status and readiness change right after the edge that alters the run state, because they are decoded from registers. Each cycle the bench advances a reference model of its own at the rising edge, then compares every output on the falling edge. Each result is therefore checked in the first cycle it is due, and in every cycle after that.

// File: rtl/dgq_pkg.sv
package dgq_pkg;
  localparam logic [1:0] RT_NONE  = 2'd0;
  localparam logic [1:0] RT_GAP   = 2'd1;
  localparam logic [1:0] RT_AFTER = 2'd2;

  typedef struct packed {
    logic start;
    logic clear;
    logic armed;
  } dgStrobesT;
endpackage

// File: rtl/dgq_ctrl.sv
module dgq_ctrl
  import dgq_pkg::*;
#(
  parameter int MIN_GAP = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigIn,
  input  logic       clearIn,
  input  logic [1:0] retrigMode,
  input  logic       busyLongest,
  input  logic       anyDone,
  input  logic       allDone,
  output dgStrobesT  strobes,
  output logic       busy,
  output logic       ready,
  output logic       shortDone,
  output logic       longDone
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic          activeQ;
  logic [GW-1:0] gapCnt;
  logic          accept;

  // Readiness depends on the selected retrigger policy
  always_comb begin
    if (!activeQ) ready = 1'b1;
    else begin
      case (retrigMode)
        RT_GAP:   ready = (gapCnt == GW'(MIN_GAP));
        RT_AFTER: ready = allDone;
        default:  ready = 1'b0;
      endcase
    end
  end

  assign accept = trigIn && ready && !clearIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      gapCnt  <= '0;
    end else if (clearIn) begin
      activeQ <= 1'b0;
      gapCnt  <= '0;
    end else if (accept) begin
      activeQ <= 1'b1;
      gapCnt  <= '0;
    end else if (activeQ && gapCnt != GW'(MIN_GAP)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  assign strobes.start = accept;
  assign strobes.clear = clearIn;
  assign strobes.armed = activeQ;

  assign busy      = activeQ && !(busyLongest ? allDone : anyDone);
  assign shortDone = activeQ && anyDone;
  assign longDone  = activeQ && allDone;

  // R5: a run always opens with busy high
  assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.start |=> busy);

  // R10: under the after-longest policy a retrigger needs every channel elapsed
  assert_after_long_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.start && activeQ && retrigMode == RT_AFTER) |-> allDone);
endmodule

// File: rtl/dgq_datapath.sv
module dgq_datapath
  import dgq_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DELAY_W = 24,
  parameter int PULSE_W = 20
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dgStrobesT                  strobes,
  input  logic                       wrEn,
  input  logic [$clog2(NUM_CH)-1:0]  wrSel,
  input  logic [DELAY_W-1:0]         wrData,
  input  logic [NUM_CH/2-1:0]        couplePair,
  output logic [NUM_CH-1:0]          levelOut,
  output logic [NUM_CH-1:0]          pulseOut,
  output logic                       anyDone,
  output logic                       allDone
);
  localparam int SEL_W = $clog2(NUM_CH);
  localparam int PCW   = $clog2(PULSE_W + 1);
  localparam int NPAIR = NUM_CH / 2;

  logic [DELAY_W-1:0] elapsed;
  logic [NUM_CH-1:0]  doneQ;

  assign anyDone = |doneQ;
  assign allDone = &doneQ;

  // One shared elapsed-time counter; it parks once every channel has fired
  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear) elapsed <= '0;
    else if (strobes.start)     elapsed <= DELAY_W'(1);
    else if (strobes.armed && !allDone) elapsed <= elapsed + 1'b1;
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : gCh
    logic [DELAY_W-1:0] delayQ;
    logic [DELAY_W-1:0] effDelay;
    logic [PCW-1:0]     pulseCnt;
    logic               hit;

    always_ff @(posedge clk) begin
      if (!rstN) delayQ <= '0;
      else if (wrEn && wrSel == SEL_W'(k)) delayQ <= wrData;
    end

    assign effDelay = (delayQ == '0) ? DELAY_W'(1) : delayQ;
    assign hit = strobes.armed && !doneQ[k] && (elapsed == effDelay);

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clear || strobes.start) begin
        doneQ[k] <= 1'b0;
        pulseCnt <= '0;
      end else if (hit) begin
        doneQ[k] <= 1'b1;
        pulseCnt <= PCW'(PULSE_W);
      end else if (pulseCnt != '0) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end

    assign pulseOut[k] = (pulseCnt != '0);

    // R1: an elapsed flag only drops on clear or an accepted retrigger
    assert_done_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
      (doneQ[k] && !strobes.start && !strobes.clear) |=> doneQ[k]);

    // R3: a pulse never appears on a channel that has not elapsed
    assert_pulse_after_done_R3: assert property (@(posedge clk) disable iff (!rstN)
      pulseOut[k] |-> doneQ[k]);
  end

  // Level decode per pair: coupled pairs turn the lower channel into a window
  for (genvar p = 0; p < NPAIR; p++) begin : gPair
    assign levelOut[2*p]   = couplePair[p] ? (doneQ[2*p] && !doneQ[2*p+1]) : doneQ[2*p];
    assign levelOut[2*p+1] = doneQ[2*p+1];
  end
endmodule

// File: rtl/dgq_top.sv
module dgq_top
  import dgq_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int DELAY_W = 24,
  parameter int PULSE_W = 20,
  parameter int MIN_GAP = 20
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      trigIn,
  input  logic                      clearIn,
  input  logic                      wrEn,
  input  logic [$clog2(NUM_CH)-1:0] wrSel,
  input  logic [DELAY_W-1:0]        wrData,
  input  logic [NUM_CH/2-1:0]       couplePair,
  input  logic                      busyLongest,
  input  logic [1:0]                retrigMode,
  output logic [NUM_CH-1:0]         levelOut,
  output logic [NUM_CH-1:0]         pulseOut,
  output logic                      busyOut,
  output logic                      shortDone,
  output logic                      longDone,
  output logic                      readyOut
);
  dgStrobesT strobes;
  logic      anyDone;
  logic      allDone;

  dgq_ctrl #(.MIN_GAP(MIN_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .clearIn(clearIn),
    .retrigMode(retrigMode), .busyLongest(busyLongest),
    .anyDone(anyDone), .allDone(allDone), .strobes(strobes),
    .busy(busyOut), .ready(readyOut), .shortDone(shortDone), .longDone(longDone)
  );

  dgq_datapath #(.NUM_CH(NUM_CH), .DELAY_W(DELAY_W), .PULSE_W(PULSE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .couplePair(couplePair), .levelOut(levelOut),
    .pulseOut(pulseOut), .anyDone(anyDone), .allDone(allDone)
  );

  // R7: a clear leaves every output quiet on the next cycle
  assert_clear_quiets_R7: assert property (@(posedge clk) disable iff (!rstN)
    clearIn |=> (levelOut == '0 && pulseOut == '0 && !busyOut && !shortDone));

  // R6: all elapsed implies some elapsed
  assert_long_implies_short_R6: assert property (@(posedge clk) disable iff (!rstN)
    longDone |-> shortDone);
endmodule

// File: tb/sim_dgq_top.sv
`timescale 1ns/1ps
module sim_dgq_top;
  localparam int PW  = 20;
  localparam int GAP = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigIn = 1'b0, clearIn = 1'b0, wrEn = 1'b0, busyLongest = 1'b0;
  logic [1:0]  wrSel = '0, couplePair = '0, retrigMode = '0;
  logic [23:0] wrData = '0;
  logic [3:0]  levelOut, pulseOut;
  logic        busyOut, shortDone, longDone, readyOut;

  always #2.5 clk = ~clk;

  dgq_top u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .clearIn(clearIn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .couplePair(couplePair),
    .busyLongest(busyLongest), .retrigMode(retrigMode), .levelOut(levelOut),
    .pulseOut(pulseOut), .busyOut(busyOut), .shortDone(shortDone),
    .longDone(longDone), .readyOut(readyOut)
  );

  int checkCnt = 0, failCnt = 0;
  string phaseTag = "R12";

  // Reference model state
  bit          mActive = 1'b0;
  int          mSince = 0;
  logic [23:0] mDly [4] = '{default: '0};

  function automatic int effOf(logic [23:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic logic [3:0] expDone();
    logic [3:0] r;
    for (int k = 0; k < 4; k++) r[k] = mActive && (mSince >= effOf(mDly[k]));
    return r;
  endfunction

  function automatic logic [3:0] expPulse();
    logic [3:0] r;
    for (int k = 0; k < 4; k++)
      r[k] = mActive && (mSince >= effOf(mDly[k])) && (mSince < effOf(mDly[k]) + PW);
    return r;
  endfunction

  function automatic logic [3:0] expLevel();
    logic [3:0] d, r;
    d = expDone();
    for (int p = 0; p < 2; p++) begin
      r[2*p]   = couplePair[p] ? (d[2*p] && !d[2*p+1]) : d[2*p];
      r[2*p+1] = d[2*p+1];
    end
    return r;
  endfunction

  function automatic logic expReady();
    if (!mActive) return 1'b1;
    case (retrigMode)
      2'd1:    return mSince >= GAP;
      2'd2:    return &expDone();
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checkCnt++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s (%s) at %0t: actual=%0h expected=%0h", tag, phaseTag, $time, got, exp);
    end
  endtask

  task automatic compareAll();
    logic [3:0] d;
    d = expDone();
    check((couplePair != 0) ? "R4 level" : "R1 level", 32'(levelOut), 32'(expLevel()));
    check("R3 pulse", 32'(pulseOut), 32'(expPulse()));
    check("R5 busy", 32'(busyOut), 32'(mActive && !(busyLongest ? &d : |d)));
    check("R6 shortDone", 32'(shortDone), 32'(|d));
    check("R6 longDone", 32'(longDone), 32'(&d));
    check("R11 ready", 32'(readyOut), 32'(expReady()));
  endtask

  // One clock: model advances on the rising edge, outputs compared on the falling edge
  task automatic tick();
    bit acc;
    @(posedge clk);
    if (rstN) begin
      acc = trigIn && !clearIn && expReady();
      if (wrEn) mDly[wrSel] = wrData;
      if (clearIn) begin mActive = 1'b0; mSince = 0; end
      else if (acc) begin mActive = 1'b1; mSince = 0; end
      else if (mActive && mSince < 100000000) mSince++;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulseTrig();
    trigIn = 1'b1; tick(); trigIn = 1'b0;
  endtask

  task automatic doClear();
    clearIn = 1'b1; tick(); clearIn = 1'b0;
  endtask

  task automatic loadDelays(int d0, int d1, int d2, int d3);
    int v[4];
    v = '{d0, d1, d2, d3};
    for (int k = 0; k < 4; k++) begin
      wrEn = 1'b1; wrSel = 2'(k); wrData = 24'(v[k]); tick();
    end
    wrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    // R12: reset state
    repeat (3) @(negedge clk);
    compareAll();
    rstN = 1'b1;
    tick();

    // R1/R2/R3/R5/R8: uncoupled, busy on shortest, no retrigger; one delay is 0
    phaseTag = "R2";
    loadDelays(3, 7, 0, 12);
    phaseTag = "R8";
    pulseTrig();
    run(8);
    pulseTrig();               // ignored: run already started
    run(40);

    // R7: clear with a simultaneous trigger; delays kept for the next run
    phaseTag = "R7";
    trigIn = 1'b1; clearIn = 1'b1; tick();
    trigIn = 1'b0; clearIn = 1'b0;
    run(3);
    pulseTrig();
    run(10);
    doClear();
    run(2);

    // R4: both pairs coupled, second pair with equal delays (empty window), busy on longest
    phaseTag = "R4";
    couplePair = 2'b11; busyLongest = 1'b1;
    loadDelays(5, 9, 4, 4);
    pulseTrig();
    run(35);
    doClear();
    couplePair = 2'b00;

    // R9: gap retrigger under a constant trigger request
    phaseTag = "R9";
    retrigMode = 2'd1;
    loadDelays(2, 15, 30, 45);
    trigIn = 1'b1; run(70); trigIn = 1'b0;
    run(50);
    doClear();

    // R10: retrigger only after the longest delay
    phaseTag = "R10";
    retrigMode = 2'd2;
    loadDelays(10, 20, 30, 40);
    trigIn = 1'b1; run(90); trigIn = 1'b0;
    run(30);
    doClear();

    // Random episodes
    phaseTag = "R1";
    for (int ep = 0; ep < 40; ep++) begin
      doClear();
      loadDelays($urandom_range(0, 50), $urandom_range(0, 50),
                 $urandom_range(0, 50), $urandom_range(0, 50));
      couplePair  = 2'($urandom_range(0, 3));
      busyLongest = 1'($urandom_range(0, 1));
      retrigMode  = 2'($urandom_range(0, 3));
      for (int c = 0; c < 120; c++) begin
        trigIn  = ($urandom_range(0, 7) == 0);
        clearIn = ($urandom_range(0, 59) == 0);
        tick();
      end
      trigIn = 1'b0; clearIn = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule